// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides which source feeds a protected output rail: the main supply or a backup battery. It does not measure voltages itself. Three digital flags come from analog comparators elsewhere: the main supply is above the reset threshold, the main supply is above the battery voltage, and the main supply has fallen under a minimum operating level. From these flags the block drives two switch enables, one per path, and a mode flag that reports the source it has chosen.

Each comparator flag passes through a two-flop synchronizer before the block uses it. The decision has memory. The chosen mode is held in a register and changes only when the synchronized flags call for a change. Each time the switches hand over from one path to the other, there is one clock cycle with both switches open, so the two sources are never shorted together. A seal input, driven by a separate sealing block, can keep the battery disconnected. While it is active, the block either closes the main switch or leaves both switches open.

Top module: `backup_switchover_ctrl`

## Requirements
- R1: After reset, both enables and the mode flag are 0 until the flags have passed the synchronizer. The earliest enable goes high on the third rising clock edge after reset is released.
- R2: With the main supply below the threshold (thr flag 0) and below the battery (above-battery flag 0), the block selects battery mode and closes the battery switch.
- R3: While the above-battery flag is 1 and the low flag is 0, the block selects main mode, whatever the threshold flag is.
- R4: While the threshold flag is 1 and the low flag is 0, the block selects main mode, even when the battery is higher.
- R5: In battery mode, the block returns to main mode as soon as either the threshold flag or the above-battery flag becomes 1. Until then it stays in battery mode.
- R6: While the low flag is 1, the block selects battery mode, whatever the other flags are.
- R7: The main enable and the battery enable are never 1 in the same cycle.
- R8: On every handover between paths, both enables are 0 for exactly one cycle before the new enable goes to 1.
- R9: While seal is 1, the battery enable is 0 from the next cycle on. The main enable closes only if main mode is chosen; otherwise both enables are 0.
- R10: A change on a raw comparator flag reaches the mode flag on the third rising edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_above_thr_i | input | 1 | Raw flag: main supply above the reset threshold |
| main_above_bat_i | input | 1 | Raw flag: main supply above the battery voltage |
| main_below_min_i | input | 1 | Raw flag: main supply below the minimum operating level |
| seal_i | input | 1 | Synchronous seal request; 1 keeps the battery path off |
| main_sw_en_o | output | 1 | Main-path switch enable |
| bat_sw_en_o | output | 1 | Battery-path switch enable |
| on_battery_o | output | 1 | Mode flag: 1 = battery mode chosen |

## Verification
The assertions check on every cycle the properties that do not depend on a scenario. They check that the two enables are never 1 together, that a closed switch is never followed directly by the other switch, that seal keeps the battery switch open, that the low flag forces battery mode, and that both enables stay 0 before the synchronized flags are valid. The memory of battery mode and the R3 main-mode rule are also asserted, using the synchronized flags. Only the bench scenarios can show the rest. They check the exact latency through the synchronizer and which recovery condition ends battery mode first. They also check that a sealed battery mode leaves both switches open, and that the one-cycle gap ends on the new path and not the old one.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_MAIN = 2'd1,
    PATH_BAT  = 2'd2
  } path_e;

  typedef enum logic {
    MODE_MAIN = 1'b0,
    MODE_BAT  = 1'b1
  } mode_e;

  typedef struct packed {
    logic low;  // main supply under minimum operating level
    logic gt;   // main supply above battery
    logic thr;  // main supply above reset threshold
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);

  // Mode decision with memory: low forces battery; otherwise leave main
  // only when main is under both threshold and battery, and leave battery
  // on the first recovery condition.
  function automatic mode_e next_mode(input mode_e cur, input flags_t f);
    mode_e nxt;
    if (f.low) begin
      nxt = MODE_BAT;
    end else if (cur == MODE_MAIN) begin
      nxt = (!f.thr && !f.gt) ? MODE_BAT : MODE_MAIN;
    end else begin
      nxt = (f.thr || f.gt) ? MODE_MAIN : MODE_BAT;
    end
    return nxt;
  endfunction

  // Path wanted for a given mode, with seal vetoing the battery path.
  function automatic path_e target_path(input logic ready, input mode_e m,
                                        input logic seal);
    path_e p;
    if (!ready) begin
      p = PATH_NONE;
    end else if (m == MODE_BAT) begin
      p = seal ? PATH_NONE : PATH_BAT;
    end else begin
      p = PATH_MAIN;
    end
    return p;
  endfunction

  // Break-before-make step: an active path that must change opens first.
  function automatic path_e step_path(input path_e cur, input path_e tgt);
    path_e p;
    if (cur != PATH_NONE && cur != tgt) begin
      p = PATH_NONE;
    end else begin
      p = tgt;
    end
    return p;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
  import bsw_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t flags_i,
  output logic   ready_o,
  output mode_e  mode_o
);

  localparam int unsigned CNT_W = $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STAGES);

  logic [CNT_W-1:0] fill_q;
  mode_e            mode_q;

  assign ready_o = (fill_q == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (!ready_o) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MAIN;
    end else if (ready_o) begin
      mode_q <= next_mode(mode_q, flags_i);
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/path_sequencer.sv
module path_sequencer
  import bsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ready_i,
  input  mode_e mode_i,
  input  logic  seal_i,
  output path_e path_o
);

  path_e path_q;
  path_e want;

  assign want = target_path(ready_i, mode_i, seal_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) path_q <= PATH_NONE;
    else        path_q <= step_path(path_q, want);
  end

  assign path_o = path_q;

endmodule

// File: rtl/backup_switchover_ctrl.sv
module backup_switchover_ctrl
  import bsw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_above_thr_i,
  input  logic main_above_bat_i,
  input  logic main_below_min_i,
  input  logic seal_i,
  output logic main_sw_en_o,
  output logic bat_sw_en_o,
  output logic on_battery_o
);

  flags_t raw_flags;
  flags_t sync_flags;
  logic   flags_ready;
  mode_e  cur_mode;
  path_e  cur_path;

  // named internal events for the checker
  logic thr_s;
  logic gt_s;
  logic low_s;

  assign raw_flags = '{low: main_below_min_i, gt: main_above_bat_i,
                       thr: main_above_thr_i};

  flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (sync_flags)
  );

  assign thr_s = sync_flags.thr;
  assign gt_s  = sync_flags.gt;
  assign low_s = sync_flags.low;

  mode_tracker #(.STAGES(SYNC_STAGES)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (sync_flags),
    .ready_o (flags_ready),
    .mode_o  (cur_mode)
  );

  path_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (flags_ready),
    .mode_i  (cur_mode),
    .seal_i  (seal_i),
    .path_o  (cur_path)
  );

  assign main_sw_en_o = (cur_path == PATH_MAIN);
  assign bat_sw_en_o  = (cur_path == PATH_BAT);
  assign on_battery_o = (cur_mode == MODE_BAT);

endmodule

// File: rtl/backup_switchover_chk.sv
module backup_switchover_chk (
  input logic clk,
  input logic rst_n,
  input logic seal_i,
  input logic main_sw_en_o,
  input logic bat_sw_en_o,
  input logic on_battery_o,
  input logic flags_ready,
  input logic thr_s,
  input logic gt_s,
  input logic low_s
);

  // R7
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_sw_en_o && bat_sw_en_o));

  // R8
  main_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_sw_en_o |=> !bat_sw_en_o);

  // R8
  bat_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sw_en_o |=> !main_sw_en_o);

  // R9
  seal_blocks_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seal_i |=> !bat_sw_en_o);

  // R6
  low_forces_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_ready && low_s) |=> on_battery_o);

  // R1
  init_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_ready |-> (!main_sw_en_o && !bat_sw_en_o && !on_battery_o));

  // R5
  bat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_ready && on_battery_o && !thr_s && !gt_s) |=> on_battery_o);

  // R3
  main_above_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_ready && gt_s && !low_s) |=> !on_battery_o);

endmodule

bind backup_switchover_ctrl backup_switchover_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seal_i       (seal_i),
  .main_sw_en_o (main_sw_en_o),
  .bat_sw_en_o  (bat_sw_en_o),
  .on_battery_o (on_battery_o),
  .flags_ready  (flags_ready),
  .thr_s        (thr_s),
  .gt_s         (gt_s),
  .low_s        (low_s)
);

// File: tb/backup_switchover_ctrl_tb.sv
module backup_switchover_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr = 1'b0, gt = 1'b0, low = 1'b0, seal = 1'b0;
  logic main_en, bat_en, on_bat;

  always #5 clk = ~clk;

  backup_switchover_ctrl u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .main_above_thr_i (thr),
    .main_above_bat_i (gt),
    .main_below_min_i (low),
    .seal_i           (seal),
    .main_sw_en_o     (main_en),
    .bat_sw_en_o      (bat_en),
    .on_battery_o     (on_bat)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference: raw flag history in a queue, ints for state.
  // path code: 0 none, 1 main, 2 battery
  logic [2:0] hist[$];
  int  edges = 0;
  int  m_bat = 0;
  int  m_path = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000};
      edges = 0; m_bat = 0; m_path = 0;
    end else begin
      logic [2:0] seen;   // {low, gt, thr} as the block sees them now
      int want;
      int new_bat;
      seen = hist[1];
      new_bat = m_bat;
      if (edges >= 2) begin
        if (seen[2]) new_bat = 1;
        else if (m_bat == 0) new_bat = (!seen[0] && !seen[1]) ? 1 : 0;
        else new_bat = (seen[0] || seen[1]) ? 0 : 1;
      end
      if (edges < 2) want = 0;
      else if (m_bat == 1) want = seal ? 0 : 2;
      else want = 1;
      if (m_path != 0 && want != m_path) m_path = 0;
      else m_path = want;
      m_bat = new_bat;
      hist.push_front({low, gt, thr});
      void'(hist.pop_back());
      edges++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (main_en !== (m_path == 1) || bat_en !== (m_path == 2) ||
          on_bat !== (m_bat == 1)) begin
        n_bad++;
        $display("FAIL %s: got main=%b bat=%b mode=%b, want main=%b bat=%b mode=%b",
                 cur_req, main_en, bat_en, on_bat, m_path == 1, m_path == 2, m_bat == 1);
      end
      n_vec++;
      if (main_en && bat_en) begin  // R7
        n_bad++;
        $display("FAIL R7: got main=%b bat=%b, want not both", main_en, bat_en);
      end
    end
  end

  task automatic run(input int n, input string req);
    cur_req = req;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic t, input logic g, input logic l, input logic s);
    thr = t; gt = g; low = l; seal = s;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    drive(1, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs idle until flags synchronized
    @(negedge clk);
    n_vec++;
    if (main_en !== 1'b0 || bat_en !== 1'b0 || on_bat !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got main=%b bat=%b mode=%b, want 0 0 0", main_en, bat_en, on_bat);
    end
    run(6, "R1");
    // R3: above battery, below threshold -> main
    drive(0, 1, 0, 0); run(6, "R3");
    // R2: below both -> battery, gap on the way (R8)
    drive(0, 0, 0, 0); run(2, "R10"); run(6, "R2");
    // R5: recovery through above-battery flag
    drive(0, 1, 0, 0); run(6, "R5");
    drive(0, 0, 0, 0); run(6, "R8");
    // R5: recovery through threshold flag
    drive(1, 0, 0, 0); run(6, "R5");
    // R4: above threshold, battery higher -> stays main
    run(4, "R4");
    // R6: low level forces battery despite good flags
    drive(1, 1, 1, 0); run(6, "R6");
    // R9: seal while battery chosen -> both off
    seal = 1'b1; run(6, "R9");
    // R9: seal with main conditions -> main only
    drive(1, 1, 0, 1); run(6, "R9");
    drive(0, 0, 0, 1); run(6, "R9");
    seal = 1'b0; run(6, "R2");
    // short pulse of the threshold flag
    thr = 1'b1; @(negedge clk); thr = 1'b0; run(8, "R5");
    drive(1, 1, 0, 0); run(6, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule